// File: doc/BRIEF.md
# Composite-Field AES S-box

This block performs the AES byte substitution without a 256-entry table. The input byte is taken to an equivalent tower representation in which it is a degree-one polynomial over GF(2^4), and each GF(2^4) element is itself a pair of GF(2^2) coefficients. The multiplicative inverse is formed there from a few nibble multipliers, one nibble squarer-times-constant and a single GF(2^4) inverter. The result is mapped back to the polynomial basis, and the AES affine transform is applied.

The block is purely combinational and contains no storage of any kind. It is intended to be dropped between pipeline registers inside a wide, heavily pipelined round datapath, where a table would cost memory or a large amount of LUT logic. The basis-change matrices and the tower constant are derived at elaboration from the field definitions, so the gate network is fixed once the design is built.

Top module: `tower_sbox`

## Requirements
- R1: Input 0x00 produces output 0x63 (zero is treated as its own inverse).
- R2: For every nonzero input x, the output equals A(x^-1), where x^-1 is the inverse modulo the polynomial 0x11B and A(b) = b ^ rotl(b,1) ^ rotl(b,2) ^ rotl(b,3) ^ rotl(b,4) ^ 0x63, with rotl a left rotation of the 8-bit value.
- R3: No input maps to itself (output never equals input).
- R4: No input maps to its bitwise complement (output never equals ~input).
- R5: The mapping is a bijection: the 256 inputs produce 256 distinct outputs.
- R6: The block has no clock and no state: the output follows a new input without any clock edge, holds steady across clock edges while the input is held, and the same input always gives the same output.
- R7: Known vectors: 0x01->0x7C, 0x02->0x77, 0x10->0xCA, 0x53->0xED, 0x63->0xFB, 0x80->0xCD, 0xC9->0xDD, 0xFF->0x16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| in_byte | input | 8 | Byte to be substituted, polynomial basis |
| out_byte | output | 8 | Substituted byte, polynomial basis |

## Verification
An exhaustive sweep over all 256 inputs is compared with a reference that raises the input to the 254th power by square-and-multiply modulo 0x11B, which separates errors in the tower arithmetic, in either basis change or in the affine step from a correct build. The same sweep records every output so that a collision, a fixed point or a complement fixed point is caught, which points at a wrong tower constant or a singular basis matrix even when only a few entries are off. A short table of well-known vectors guards against a reference and design that agree on a wrong convention, and directed steps change the input between clock edges to show the output needs no edge.

// File: rtl/tower_sbox.sv
module tower_sbox (
  input  logic [7:0] in_byte,
  output logic [7:0] out_byte
);

  // GF(2^2): x^2 = x + 1
  function automatic logic [1:0] g4_mul(input logic [1:0] p, input logic [1:0] q);
    g4_mul = {(p[1] & q[1]) ^ (p[1] & q[0]) ^ (p[0] & q[1]),
              (p[1] & q[1]) ^ (p[0] & q[0])};
  endfunction

  function automatic logic [1:0] g4_sq(input logic [1:0] p);
    g4_sq = {p[1], p[1] ^ p[0]};
  endfunction

  // GF(2^4) over GF(2^2): y^2 = y + PHI
  localparam logic [1:0] PHI = 2'b10;

  function automatic logic [3:0] g16_mul(input logic [3:0] u, input logic [3:0] v);
    logic [1:0] ac, ae, bc, be;
    ac = g4_mul(u[3:2], v[3:2]);
    ae = g4_mul(u[3:2], v[1:0]);
    bc = g4_mul(u[1:0], v[3:2]);
    be = g4_mul(u[1:0], v[1:0]);
    g16_mul = {ac ^ ae ^ bc, g4_mul(ac, PHI) ^ be};
  endfunction

  function automatic logic [3:0] g16_sq(input logic [3:0] u);
    g16_sq = g16_mul(u, u);
  endfunction

  function automatic logic [3:0] g16_inv(input logic [3:0] u);
    logic [1:0] a, b, dn, dinv;
    a    = u[3:2];
    b    = u[1:0];
    dn   = g4_mul(g4_sq(a), PHI) ^ g4_mul(a, b) ^ g4_sq(b);
    dinv = g4_sq(dn);
    g16_inv = {g4_mul(a, dinv), g4_mul(a ^ b, dinv)};
  endfunction

  // Smallest constant making z^2 + z + c irreducible over GF(2^4)
  function automatic logic [3:0] pick_lambda();
    logic [3:0] found;
    logic       ok;
    found = '0;
    for (int c = 1; c < 16; c++) begin
      ok = 1'b1;
      for (int t = 0; t < 16; t++)
        if ((g16_sq(4'(t)) ^ 4'(t)) == 4'(c)) ok = 1'b0;
      if (ok && found == '0) found = 4'(c);
    end
    pick_lambda = found;
  endfunction

  localparam logic [3:0] LAMBDA = pick_lambda();

  // GF(2^8) over GF(2^4): z^2 = z + LAMBDA
  function automatic logic [7:0] t8_mul(input logic [7:0] u, input logic [7:0] v);
    logic [3:0] hh, hl, lh, ll;
    hh = g16_mul(u[7:4], v[7:4]);
    hl = g16_mul(u[7:4], v[3:0]);
    lh = g16_mul(u[3:0], v[7:4]);
    ll = g16_mul(u[3:0], v[3:0]);
    t8_mul = {hh ^ hl ^ lh, g16_mul(hh, LAMBDA) ^ ll};
  endfunction

  // A tower element that is a root of x^8 + x^4 + x^3 + x + 1
  function automatic logic [7:0] find_root();
    logic [7:0] b, p2, p3, p4, p8, root;
    root = '0;
    for (int c = 1; c < 256; c++) begin
      b  = 8'(c);
      p2 = t8_mul(b, b);
      p3 = t8_mul(p2, b);
      p4 = t8_mul(p3, b);
      p8 = t8_mul(p4, p4);
      if ((p8 ^ p4 ^ p3 ^ b ^ 8'h01) == 8'h00 && root == 8'h00) root = b;
    end
    find_root = root;
  endfunction

  localparam logic [7:0] BETA = find_root();

  // Column i of a matrix sits in bits [8i+7:8i]
  function automatic logic [7:0] apply_cols(input logic [63:0] cols, input logic [7:0] v);
    logic [7:0] r;
    r = '0;
    for (int i = 0; i < 8; i++)
      if (v[i]) r = r ^ cols[8*i +: 8];
    apply_cols = r;
  endfunction

  function automatic logic [63:0] build_map_in();
    logic [63:0] cols;
    logic [7:0]  pw;
    cols = '0;
    pw   = 8'h01;
    for (int i = 0; i < 8; i++) begin
      cols[8*i +: 8] = pw;
      pw = t8_mul(pw, BETA);
    end
    build_map_in = cols;
  endfunction

  localparam logic [63:0] MAP_IN = build_map_in();

  function automatic logic [63:0] build_map_out();
    logic [63:0] cols;
    cols = '0;
    for (int j = 0; j < 8; j++)
      for (int c = 0; c < 256; c++)
        if (apply_cols(MAP_IN, 8'(c)) == (8'h01 << j)) cols[8*j +: 8] = 8'(c);
    build_map_out = cols;
  endfunction

  localparam logic [63:0] MAP_OUT = build_map_out();

  function automatic logic [7:0] affine(input logic [7:0] v);
    affine = v ^ {v[6:0], v[7]} ^ {v[5:0], v[7:6]} ^ {v[4:0], v[7:5]}
               ^ {v[3:0], v[7:4]} ^ 8'h63;
  endfunction

  logic [7:0] tw, tw_inv, poly_inv;
  logic [3:0] hi_n, lo_n, dlt, dlt_inv;

  assign tw       = apply_cols(MAP_IN, in_byte);
  assign hi_n     = tw[7:4];
  assign lo_n     = tw[3:0];
  assign dlt      = g16_mul(g16_sq(hi_n), LAMBDA) ^ g16_mul(hi_n, lo_n) ^ g16_sq(lo_n);
  assign dlt_inv  = g16_inv(dlt);
  assign tw_inv   = {g16_mul(hi_n, dlt_inv), g16_mul(hi_n ^ lo_n, dlt_inv)};
  assign poly_inv = apply_cols(MAP_OUT, tw_inv);
  assign out_byte = affine(poly_inv);

endmodule

// File: rtl/tower_sbox_chk.sv
module tower_sbox_chk (
  input logic [7:0] in_byte,
  input logic [7:0] out_byte
);

  function automatic logic [7:0] pmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc, x;
    acc = '0;
    x   = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ x;
      x = x[7] ? ({x[6:0], 1'b0} ^ 8'h1B) : {x[6:0], 1'b0};
    end
    pmul = acc;
  endfunction

  function automatic logic [7:0] unaffine(input logic [7:0] s);
    unaffine = {s[6:0], s[7]} ^ {s[4:0], s[7:5]} ^ {s[1:0], s[7:2]} ^ 8'h05;
  endfunction

  logic [7:0] recovered;
  assign recovered = unaffine(out_byte);

  always_comb begin
    // R1
    zero_map_chk: assert (in_byte != 8'h00 || out_byte == 8'h63)
      else $error("zero input gave %02h", out_byte);
    // R2
    inverse_chk: assert (in_byte == 8'h00 || pmul(in_byte, recovered) == 8'h01)
      else $error("input %02h output %02h is not affine of inverse", in_byte, out_byte);
    // R3
    fixed_point_chk: assert (out_byte != in_byte)
      else $error("fixed point at %02h", in_byte);
    // R4
    anti_fixed_chk: assert (out_byte != ~in_byte)
      else $error("complement fixed point at %02h", in_byte);
  end

endmodule

bind tower_sbox tower_sbox_chk u_chk (.in_byte(in_byte), .out_byte(out_byte));

// File: tb/tower_sbox_bench.sv
`timescale 1ns/1ps
module tower_sbox_bench;

  logic       clk = 1'b0;
  logic [7:0] din = 8'h00;
  logic [7:0] dout;
  logic       done = 1'b0;
  int         n_cmp = 0;
  int         n_bad = 0;
  bit         seen [256];

  always #2.5 clk = ~clk;

  tower_sbox u_tower_sbox (.in_byte(din), .out_byte(dout));

  // R7 vectors: {input, expected output}
  localparam logic [15:0] VEC [8] = '{
    16'h017C, 16'h0277, 16'h10CA, 16'h53ED,
    16'h63FB, 16'h80CD, 16'hC9DD, 16'hFF16
  };

  function automatic logic [7:0] rmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc, x;
    acc = '0;
    x   = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ x;
      x = x[7] ? ({x[6:0], 1'b0} ^ 8'h1B) : {x[6:0], 1'b0};
    end
    return acc;
  endfunction

  function automatic logic [7:0] rsub(input logic [7:0] a);
    logic [7:0] r, b, v;
    r = 8'h01;
    b = a;
    for (int e = 254, k = 0; k < 8; k++) begin
      if (e[k]) r = rmul(r, b);
      b = rmul(b, b);
    end
    v = r;
    return v ^ {v[6:0], v[7]} ^ {v[5:0], v[7:6]} ^ {v[4:0], v[7:5]}
             ^ {v[3:0], v[7:4]} ^ 8'h63;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [7:0] in_v,
                       input logic [7:0] act, input string exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s in=%02h actual=%02h expected=%s", tag, in_v, act, exp);
    end
  endtask

  task automatic apply(input logic [7:0] v);
    @(negedge clk);
    din = v;
    #1;
  endtask

  initial begin
    // reset state: input held at zero from time zero, R1
    #1;
    check(dout == 8'h63, "R1 initial", din, dout, "63");

    // table walk, R7
    foreach (VEC[i]) begin
      apply(VEC[i][15:8]);
      check(dout == VEC[i][7:0], "R7 vector", VEC[i][15:8], dout,
            $sformatf("%02h", VEC[i][7:0]));
    end

    // exhaustive sweep: R1 R2 R3 R4, collect for R5
    for (int x = 0; x < 256; x++) begin
      logic [7:0] xv, ev;
      xv = 8'(x);
      ev = rsub(xv);
      apply(xv);
      check(dout == ev, (x == 0) ? "R1 sweep" : "R2 sweep", xv, dout,
            $sformatf("%02h", ev));
      check(dout != xv, "R3 fixed point", xv, dout, $sformatf("not %02h", xv));
      check(dout != ~xv, "R4 complement", xv, dout, $sformatf("not %02h", ~xv));
      if (seen[dout])
        check(1'b0, "R5 duplicate", xv, dout, "unused value");
      seen[dout] = 1'b1;
    end
    begin
      int cnt;
      cnt = 0;
      foreach (seen[i]) if (seen[i]) cnt++;
      check(cnt == 256, "R5 distinct outputs", 8'h00, 8'(cnt),
            "256 distinct");
    end

    // R6: change between edges, no clock edge needed
    @(posedge clk);
    #0.5;
    din = 8'h53;
    #1;
    check(dout == 8'hED, "R6 no-edge update", din, dout, "ed");
    din = 8'hFF;
    #0.5;
    check(dout == 8'h16, "R6 second no-edge update", din, dout, "16");
    repeat (3) @(posedge clk);
    #1;
    check(dout == 8'h16, "R6 held across edges", din, dout, "16");
    apply(8'h00);
    check(dout == 8'h63, "R1 return to zero", din, dout, "63");
    apply(8'h53);
    check(dout == 8'hED, "R6 repeat input", din, dout, "ed");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule